// File: doc/BRIEF.md
# Three-Mode Automatic Sequence Counter

This block is a free-running synchronous sequence generator with a four-bit output, `cnt_o[3]` the most significant bit and `cnt_o[0]` the least. On each clock where the enable is high it advances one position through a fixed 14-position cycle. The cycle is built from three operating modes that follow each other without any outside control. First comes a binary up-count from 0000 to 0100. Next is a walking single one from 0001 to 1000. Last is a binary down-count from 0100 to 0000. The cycle then starts again.

The same output code can appear in more than one mode. For example, 0100 occurs three times and 0000 occurs twice in a row at the wrap. For this reason the successor is chosen by a hidden step register and not by the output value. That step register is an enumerated state machine with fourteen named states:

| States | Mode |
|---|---|
| `ST_UP0`..`ST_UP4` | up-count |
| `ST_WK0`..`ST_WK3` | walk |
| `ST_DN0`..`ST_DN4` | down-count |

The state transitions are:

- UPn→UPn+1
- UP4→WK0 (up-to-walk change)
- WKn→WKn+1
- WK3→DN0 (walk-to-down change)
- DNn→DNn+1
- DN4→UP0 (the wrap)

A state code outside the fourteen named codes leads back to `ST_UP0` on the next enabled clock. Both the output and the mode indicator come from flip-flops, so they change only at a clock edge.

Top module: `seq3_counter`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the block goes to step 0. After that edge `cnt_o` is 0000 and `mode_o` is 0.
- R2: In the up-count mode (`mode_o` = 0), successive enabled clocks give 0000, 0001, 0010, 0011, 0100.
- R3: In the walk mode (`mode_o` = 1), successive enabled clocks give 0001, 0010, 0100, 1000. Exactly one bit is set, and it moves one position toward bit 3 on each enabled clock.
- R4: In the down-count mode (`mode_o` = 2), successive enabled clocks give 0100, 0011, 0010, 0001, 0000.
- R5: The cycle has exactly 14 enabled clocks and repeats forever. After the down-count's 0000, the next enabled clock gives 0000 with `mode_o` = 0, and the clock after that gives 0001.
- R6: When `en_i` is low at a rising edge, `cnt_o` and `mode_o` keep their values. The sequence then continues from where it stopped.
- R7: `mode_o` takes only the values 0 (up), 1 (walk) and 2 (down), and never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Advance enable; low holds the sequence |
| cnt_o | output | 4 | Registered sequence output, bit 3 most significant |
| mode_o | output | 2 | Registered mode: 0 up, 1 walk, 2 down |

## Verification
Two events can fall in the same cycle. One is a mode change, which happens at the UP4, WK3 and DN4 steps. The other is a hold caused by a low enable. The bench drops `en_i` exactly on each boundary step. It then checks that neither the output nor the mode moves, and that the next enabled clock still takes the correct cross-mode successor. The double 0000 at the wrap is judged the same way: a stall between the two zero steps must not merge them or skip one.

// File: rtl/seqc_pkg.sv
package seqc_pkg;

    localparam int OUT_W   = 4;
    localparam int MODE_W  = 2;
    localparam int STEP_W  = 4;
    localparam int N_STEPS = 14;
    localparam int UP_LEN  = 5;
    localparam int WK_LEN  = 4;
    localparam int DN_LEN  = 5;
    localparam int WK_BASE = UP_LEN;
    localparam int DN_BASE = UP_LEN + WK_LEN;
    localparam int LAST    = N_STEPS - 1;

    typedef enum logic [STEP_W-1:0] {
        ST_UP0, ST_UP1, ST_UP2, ST_UP3, ST_UP4,
        ST_WK0, ST_WK1, ST_WK2, ST_WK3,
        ST_DN0, ST_DN1, ST_DN2, ST_DN3, ST_DN4
    } step_e;

    typedef enum logic [MODE_W-1:0] {
        MODE_UP   = 2'd0,
        MODE_WALK = 2'd1,
        MODE_DOWN = 2'd2
    } mode_e;

endpackage

// File: rtl/seqc_step_fsm.sv
module seqc_step_fsm
    import seqc_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  en_i,
    output step_e step_q_o,
    output step_e step_d_o
);

    step_e step_q;
    step_e step_nx;

    // Next-state function: every named transition of the cycle.
    always_comb begin
        unique case (step_q)
            ST_UP0:  step_nx = ST_UP1;
            ST_UP1:  step_nx = ST_UP2;
            ST_UP2:  step_nx = ST_UP3;
            ST_UP3:  step_nx = ST_UP4;
            ST_UP4:  step_nx = ST_WK0;   // up -> walk
            ST_WK0:  step_nx = ST_WK1;
            ST_WK1:  step_nx = ST_WK2;
            ST_WK2:  step_nx = ST_WK3;
            ST_WK3:  step_nx = ST_DN0;   // walk -> down
            ST_DN0:  step_nx = ST_DN1;
            ST_DN1:  step_nx = ST_DN2;
            ST_DN2:  step_nx = ST_DN3;
            ST_DN3:  step_nx = ST_DN4;
            ST_DN4:  step_nx = ST_UP0;   // wrap
            default: step_nx = ST_UP0;   // illegal code recovery
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            step_q <= ST_UP0;
        end else if (en_i) begin
            step_q <= step_nx;
        end
    end

    assign step_q_o = step_q;
    assign step_d_o = rst_i ? ST_UP0 : (en_i ? step_nx : step_q);

    // R7: the step index never leaves the 14 legal codes
    a_r7_step_legal: assert property (@(posedge clk_i) disable iff (rst_i)
        int'(step_q) <= LAST);

    // R5: the last step always wraps to the first on an enabled clock
    a_r5_wrap_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && step_q == ST_DN4) |=> step_q == ST_UP0);

    // R6: a disabled clock leaves the step index untouched
    a_r6_step_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(step_q));

endmodule

// File: rtl/seqc_pattern.sv
module seqc_pattern
    import seqc_pkg::*;
(
    input  step_e             step_i,
    output logic [OUT_W-1:0]  pat_o,
    output mode_e             mode_o
);

    logic [STEP_W-1:0] idx;
    logic [STEP_W-1:0] wk_ofs;
    logic [STEP_W-1:0] dn_ofs;

    assign idx    = step_i;
    assign wk_ofs = idx - STEP_W'(WK_BASE);
    assign dn_ofs = STEP_W'(LAST) - idx;

    // Mode decode from the step index range.
    always_comb begin
        if (int'(idx) < WK_BASE) begin
            mode_o = MODE_UP;
        end else if (int'(idx) < DN_BASE) begin
            mode_o = MODE_WALK;
        end else begin
            mode_o = MODE_DOWN;
        end
    end

    // Output pattern per mode.
    always_comb begin
        unique case (mode_o)
            MODE_UP:   pat_o = idx[OUT_W-1:0];
            MODE_WALK: pat_o = OUT_W'(1) << wk_ofs;
            MODE_DOWN: pat_o = dn_ofs[OUT_W-1:0];
            default:   pat_o = '0;
        endcase
    end

endmodule

// File: rtl/seqc_out_stage.sv
module seqc_out_stage
    import seqc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic [OUT_W-1:0]  pat_i,
    input  mode_e             mode_i,
    output logic [OUT_W-1:0]  cnt_o,
    output logic [MODE_W-1:0] mode_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_o  <= '0;
            mode_o <= MODE_UP;
        end else if (en_i) begin
            cnt_o  <= pat_i;
            mode_o <= mode_i;
        end
    end

    // R7: mode code 3 never appears
    a_r7_mode_legal: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_o != 2'd3);

    // R6: outputs hold when enable is low
    a_r6_out_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> ($stable(cnt_o) && $stable(mode_o)));

    // R3: walk mode is one-hot
    a_r3_walk_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_o == 2'd1 |-> $countones(cnt_o) == 1);

endmodule

// File: rtl/seq3_counter.sv
module seq3_counter
    import seqc_pkg::*;
(
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_i,
    output logic [3:0]   cnt_o,
    output logic [1:0]   mode_o
);

    step_e             step_q;
    step_e             step_d;
    logic [OUT_W-1:0]  pat;
    mode_e             pat_mode;
    logic              unused_step;

    seqc_step_fsm i_fsm (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (en_i),
        .step_q_o (step_q),
        .step_d_o (step_d)
    );

    seqc_pattern i_pat (
        .step_i (step_d),
        .pat_o  (pat),
        .mode_o (pat_mode)
    );

    seqc_out_stage i_out (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .pat_i  (pat),
        .mode_i (pat_mode),
        .cnt_o  (cnt_o),
        .mode_o (mode_o)
    );

    assign unused_step = ^step_q;

    // R2: inside up mode each enabled step adds one
    a_r2_up_increment: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && mode_o == 2'd0 && cnt_o != 4'd4 && !(cnt_o == 4'd0 && step_q == ST_DN4))
        |=> cnt_o == $past(cnt_o) + 4'd1);

    // R4: inside down mode each enabled step (before the last) subtracts one
    a_r4_down_decrement: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && mode_o == 2'd2 && cnt_o != 4'd0) |=> cnt_o == $past(cnt_o) - 4'd1);

    // R5: down-count zero is followed by up-count zero
    a_r5_double_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && mode_o == 2'd2 && cnt_o == 4'd0) |=> (cnt_o == 4'd0 && mode_o == 2'd0));

    // R3: walk bit moves one place up
    a_r3_walk_shift: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && mode_o == 2'd1 && cnt_o != 4'd8) |=> cnt_o == ($past(cnt_o) << 1));

endmodule

// File: tb/test_seq3_counter.sv
module test_seq3_counter;

    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic       en_i  = 1'b0;
    logic [3:0] cnt_o;
    logic [1:0] mode_o;

    typedef struct {
        logic [3:0] cnt;
        logic [1:0] mode;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   vectors = 0;
    int   miscomp = 0;
    int   idx     = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk_i = ~clk_i;   // 125 MHz

    seq3_counter i_seq3_counter (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .cnt_o  (cnt_o),
        .mode_o (mode_o)
    );

    // Expected pattern taken from requirements R2, R3, R4.
    function automatic logic [3:0] pat_of(input int s);
        case (s)
            0: return 4'b0000;  1: return 4'b0001;  2: return 4'b0010;
            3: return 4'b0011;  4: return 4'b0100;
            5: return 4'b0001;  6: return 4'b0010;  7: return 4'b0100;
            8: return 4'b1000;
            9: return 4'b0100; 10: return 4'b0011; 11: return 4'b0010;
           12: return 4'b0001; 13: return 4'b0000;
            default: return 4'bxxxx;
        endcase
    endfunction

    function automatic logic [1:0] mode_of(input int s);
        if (s <= 4) return 2'd0;
        if (s <= 8) return 2'd1;
        return 2'd2;
    endfunction

    // Driver: set inputs mid-cycle, advance the model, push the expectation.
    task automatic drive(input logic rst, input logic en);
        exp_t e;
        int   prev;
        @(negedge clk_i);
        rst_i = rst;
        en_i  = en;
        prev  = idx;
        if (rst)     idx = 0;
        else if (en) idx = (idx == 13) ? 0 : idx + 1;
        e.cnt  = pat_of(idx);
        e.mode = mode_of(idx);
        if (rst)                        e.tag = "R1";
        else if (!en)                   e.tag = "R6";
        else if (prev == 13 || prev == 0) e.tag = "R5";
        else if (e.mode == 2'd0)        e.tag = "R2";
        else if (e.mode == 2'd1)        e.tag = "R3";
        else                            e.tag = "R4";
        exp_q.push_back(e);
    endtask

    // Monitor: sample 2 ns after the edge, compare against the queue head.
    always @(posedge clk_i) begin
        exp_t e;
        #2;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            vectors++;
            if (cnt_o !== e.cnt || mode_o !== e.mode) begin
                miscomp++;
                $display("FAIL %s: cnt=%b mode=%0d expected cnt=%b mode=%0d",
                         e.tag, cnt_o, mode_o, e.cnt, e.mode);
            end
            vectors++;
            if (mode_o === 2'd3) begin   // R7
                miscomp++;
                $display("FAIL R7: mode=%0d expected 0..2", mode_o);
            end
        end
    end

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        miscomp++;
        $display("FAIL watchdog: run did not complete, expected finish");
        finish_run();
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b0);
        // R2..R5: two full cycles plus a few steps
        for (int i = 0; i < 32; i++) drive(1'b0, 1'b1);
        // R6: stall at every position, including each mode boundary and the wrap
        for (int k = 0; k < 15; k++) begin
            drive(1'b0, 1'b0);
            drive(1'b0, 1'b0);
            drive(1'b0, 1'b1);
        end
        // R5: stall between the two zero steps
        while (idx != 13) drive(1'b0, 1'b1);
        drive(1'b0, 1'b0);
        drive(1'b0, 1'b1);
        drive(1'b0, 1'b0);
        drive(1'b0, 1'b1);
        // R6: pseudo-random enable
        for (int i = 0; i < 120; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(1'b0, lfsr[0]);
        end
        // R1: reset in the middle of walk mode
        while (mode_of(idx) != 2'd1) drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);
        for (int i = 0; i < 30; i++) drive(1'b0, 1'b1);
        // drain
        while (exp_q.size() > 0) @(negedge clk_i);
        @(negedge clk_i);
        finish_run();
    end

endmodule